// File: doc/BRIEF.md
# Compare-Driven Waveform Channel

This block is one compare channel that sits beside a shared free-running timer. It holds a 16-bit compare value that software writes and reads back, watches the timer count each clock, and, when the count reaches the compare value, raises a sticky match flag and changes a registered output pin according to a 3-bit output mode. Several copies of the channel are placed around one timer. Each copy also receives the period-end pulse that the timer raises when its count reaches the channel-0 threshold.

Two-action modes let a channel build a PWM waveform without software help. One edge is taken on the channel's own match and the opposite edge on the period end, so the compare value sets the duty cycle. Mode 0 gives software direct control of the pin. A capture-select input, when high, parks the whole compare function. A local interrupt enable gates the flag onto an interrupt request.

Top module: `ocCompareChannel`

## Requirements
- R1: A write strobe loads the compare register with the write data on the next clock edge. The register value is always visible on the read-back port, and it resets to 0.
- R2: A match event occurs on the first cycle in which the timer count equals the compare register while capture-select is 0. A count that stays equal for several cycles produces a single event. Each event sets the match flag on the next edge, whether or not the interrupt enable is set.
- R3: A flag-clear write clears the match flag on the next edge. A match event in the same cycle takes priority and leaves the flag set.
- R4: In mode 0 (mode code 3'd0), the output pin takes the software output bit on each edge.
- R5: Single-action modes act only on a match event and ignore period-end: code 1 sets the pin, code 4 toggles it, and code 5 clears it.
- R6: Two-action modes act on a match event and then on period-end. The codes and their actions are: 2 toggle then clear, 3 set then clear, 6 toggle then set, and 7 clear then set.
- R7: In a two-action mode, when a match event and period-end fall in the same cycle, the period-end action alone is applied.
- R8: While capture-select is 1, the output pin holds its value, the software bit has no effect, and no match flag is set.
- R9: The interrupt request is high exactly when both the match flag and the interrupt enable are high.
- R10: While reset is held low, the output pin, the match flag and the compare register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerCount | input | 16 | Shared timer count |
| periodEnd | input | 1 | Pulse when the count reaches the channel-0 threshold |
| cmpWrEn | input | 1 | Compare register write strobe |
| cmpWrData | input | 16 | Compare register write data |
| cmpValue | output | 16 | Compare register read-back |
| modeSel | input | 3 | Output mode code |
| captureSel | input | 1 | 1 parks the compare function |
| swOut | input | 1 | Software output bit for mode 0 |
| flagClrWr | input | 1 | Write-zero strobe for the match flag |
| intEnable | input | 1 | Local interrupt enable |
| outPin | output | 1 | Registered waveform output |
| matchFlag | output | 1 | Sticky match flag |
| irqReq | output | 1 | Interrupt request |

## Verification
The assertions assume that periodEnd is a single-cycle pulse that comes from the shared timer. They also assume that mode and capture-select change only between cycles, so the checker can treat each sampled cycle as one decision. The stimulus sweeps a wrapping counter that raises periodEnd on its top value. It holds the count steady to test single-event detection. It changes the mode only at the start of a phase, and it drives flag-clear and enable from a fixed pseudo-random sequence. A behavioural model in the bench predicts pin, flag, interrupt and read-back values on every cycle, including the match-at-threshold collision and a count that stays on the compare value.

// File: rtl/ocPkg.sv
package ocPkg;
  localparam int CNT_W = 16;

  typedef enum logic [2:0] {
    MODE_SW      = 3'd0,
    MODE_SET     = 3'd1,
    MODE_TOG_RST = 3'd2,
    MODE_SET_RST = 3'd3,
    MODE_TOG     = 3'd4,
    MODE_RST     = 3'd5,
    MODE_TOG_SET = 3'd6,
    MODE_RST_SET = 3'd7
  } outMode_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SET,
    ACT_CLR,
    ACT_TOG
  } pinAct_e;

  typedef struct packed {
    logic doLoadSw;
    logic doSet;
    logic doClr;
    logic doToggle;
    logic flagSet;
    logic flagClr;
  } ocStrobes_t;
endpackage

// File: rtl/ocControl.sv
module ocControl
  import ocPkg::*;
(
  input  logic [2:0] modeSel,
  input  logic       hitFirst,
  input  logic       periodEnd,
  input  logic       captureSel,
  input  logic       flagClrWr,
  output ocStrobes_t strobes
);
  outMode_e mode;
  pinAct_e  matchAct;
  pinAct_e  periodAct;
  pinAct_e  finalAct;
  logic     dualMode;

  assign mode = outMode_e'(modeSel);

  always_comb begin
    matchAct  = ACT_NONE;
    periodAct = ACT_NONE;
    dualMode  = 1'b0;
    unique case (mode)
      MODE_SW:      matchAct = ACT_NONE;
      MODE_SET:     matchAct = ACT_SET;
      MODE_TOG:     matchAct = ACT_TOG;
      MODE_RST:     matchAct = ACT_CLR;
      MODE_TOG_RST: begin matchAct = ACT_TOG; periodAct = ACT_CLR; dualMode = 1'b1; end
      MODE_SET_RST: begin matchAct = ACT_SET; periodAct = ACT_CLR; dualMode = 1'b1; end
      MODE_TOG_SET: begin matchAct = ACT_TOG; periodAct = ACT_SET; dualMode = 1'b1; end
      MODE_RST_SET: begin matchAct = ACT_CLR; periodAct = ACT_SET; dualMode = 1'b1; end
      default:      matchAct = ACT_NONE;
    endcase
  end

  // threshold action overrides the match action in the same cycle
  always_comb begin
    finalAct = ACT_NONE;
    if (dualMode && periodEnd) finalAct = periodAct;
    else if (hitFirst)         finalAct = matchAct;
  end

  always_comb begin
    strobes          = '0;
    strobes.flagClr  = flagClrWr;
    if (!captureSel) begin
      strobes.flagSet  = hitFirst;
      strobes.doLoadSw = (mode == MODE_SW);
      strobes.doSet    = (finalAct == ACT_SET);
      strobes.doClr    = (finalAct == ACT_CLR);
      strobes.doToggle = (finalAct == ACT_TOG);
    end
  end
endmodule

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocPkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] timerCount,
  input  logic         cmpWrEn,
  input  logic [W-1:0] cmpWrData,
  input  logic         captureSel,
  input  logic         swOut,
  input  ocStrobes_t   strobes,
  output logic [W-1:0] cmpValue,
  output logic         hitFirst,
  output logic         outPin,
  output logic         matchFlag
);
  logic [W-1:0] cmpReg;
  logic         hitNow;
  logic         hitQ;

  assign hitNow   = (timerCount == cmpReg) && !captureSel;
  assign hitFirst = hitNow && !hitQ;
  assign cmpValue = cmpReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg    <= '0;
      hitQ      <= 1'b0;
      outPin    <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      hitQ <= hitNow;
      if (cmpWrEn) cmpReg <= cmpWrData;
      if (strobes.flagSet)      matchFlag <= 1'b1;
      else if (strobes.flagClr) matchFlag <= 1'b0;
      if (strobes.doLoadSw)      outPin <= swOut;
      else if (strobes.doSet)    outPin <= 1'b1;
      else if (strobes.doClr)    outPin <= 1'b0;
      else if (strobes.doToggle) outPin <= ~outPin;
    end
  end
endmodule

// File: rtl/ocCompareChannel.sv
module ocCompareChannel
  import ocPkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] timerCount,
  input  logic         periodEnd,
  input  logic         cmpWrEn,
  input  logic [W-1:0] cmpWrData,
  output logic [W-1:0] cmpValue,
  input  logic [2:0]   modeSel,
  input  logic         captureSel,
  input  logic         swOut,
  input  logic         flagClrWr,
  input  logic         intEnable,
  output logic         outPin,
  output logic         matchFlag,
  output logic         irqReq
);
  ocStrobes_t strobes;
  logic       hitFirst;

  ocControl uCtrl (
    .modeSel   (modeSel),
    .hitFirst  (hitFirst),
    .periodEnd (periodEnd),
    .captureSel(captureSel),
    .flagClrWr (flagClrWr),
    .strobes   (strobes)
  );

  ocDatapath #(.W(W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .timerCount(timerCount),
    .cmpWrEn   (cmpWrEn),
    .cmpWrData (cmpWrData),
    .captureSel(captureSel),
    .swOut     (swOut),
    .strobes   (strobes),
    .cmpValue  (cmpValue),
    .hitFirst  (hitFirst),
    .outPin    (outPin),
    .matchFlag (matchFlag)
  );

  assign irqReq = matchFlag && intEnable;
endmodule

// File: rtl/ocCompareChannelChk.sv
module ocCompareChannelChk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] timerCount,
  input logic         periodEnd,
  input logic         cmpWrEn,
  input logic [W-1:0] cmpWrData,
  input logic [W-1:0] cmpValue,
  input logic [2:0]   modeSel,
  input logic         captureSel,
  input logic         swOut,
  input logic         flagClrWr,
  input logic         intEnable,
  input logic         outPin,
  input logic         matchFlag,
  input logic         irqReq
);
  logic eqNow;
  logic prevEq;
  assign eqNow = (timerCount == cmpValue) && !captureSel;

  always_ff @(posedge clk) begin
    if (!rstN) prevEq <= 1'b0;
    else       prevEq <= eqNow;
  end

  // R2
  first_match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eqNow && !prevEq) |=> matchFlag);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClrWr && !eqNow) |=> !matchFlag);

  // R4
  sw_mode_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 && !captureSel) |=> (outPin == $past(swOut)));

  // R5
  set_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd1 && eqNow && !prevEq) |=> outPin);

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureSel |=> $stable(outPin));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (matchFlag && intEnable));
endmodule

bind ocCompareChannel ocCompareChannelChk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .timerCount(timerCount), .periodEnd(periodEnd),
  .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .cmpValue(cmpValue),
  .modeSel(modeSel), .captureSel(captureSel), .swOut(swOut),
  .flagClrWr(flagClrWr), .intEnable(intEnable), .outPin(outPin),
  .matchFlag(matchFlag), .irqReq(irqReq)
);

// File: tb/tb_ocCompareChannel.sv
module tb_ocCompareChannel;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] timerCount;
  logic        periodEnd;
  logic        cmpWrEn;
  logic [15:0] cmpWrData;
  logic [15:0] cmpValue;
  logic [2:0]  modeSel;
  logic        captureSel;
  logic        swOut;
  logic        flagClrWr;
  logic        intEnable;
  logic        outPin;
  logic        matchFlag;
  logic        irqReq;

  always #5 clk = ~clk;

  ocCompareChannel dut (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .periodEnd(periodEnd),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .cmpValue(cmpValue),
    .modeSel(modeSel), .captureSel(captureSel), .swOut(swOut),
    .flagClrWr(flagClrWr), .intEnable(intEnable), .outPin(outPin),
    .matchFlag(matchFlag), .irqReq(irqReq)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  int unsigned lcg = 32'h1234_5678;

  // reference model state
  bit      mOut, mFlag, mPrevEq;
  int      mCmp;
  string   outTag;

  function automatic bit rnd(int modulo);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return ((lcg >> 16) % modulo) == 0;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(outTag, "outPin", 16'(outPin), 16'(mOut));
    chk("R2/R3", "matchFlag", 16'(matchFlag), 16'(mFlag));
    chk("R9", "irqReq", 16'(irqReq), 16'(mFlag && intEnable));
    chk("R1", "cmpValue", cmpValue, 16'(mCmp));
  endtask

  // inputs are already set; advance one clock and check
  task automatic step();
    bit eq, ev, nOut, nFlag, dual;
    int nCmp;
    eq    = (int'(timerCount) == mCmp) && !captureSel;
    ev    = eq && !mPrevEq;
    nFlag = ev ? 1'b1 : (flagClrWr ? 1'b0 : mFlag);
    nCmp  = cmpWrEn ? int'(cmpWrData) : mCmp;
    nOut  = mOut;
    dual  = (modeSel == 2) || (modeSel == 3) || (modeSel == 6) || (modeSel == 7);
    if (captureSel) outTag = "R8";
    else if (modeSel == 0) begin
      outTag = "R4"; nOut = swOut;
    end else if (dual && periodEnd) begin
      outTag = ev ? "R7" : "R6";
      nOut = (modeSel == 6 || modeSel == 7);
    end else if (ev) begin
      outTag = dual ? "R6" : "R5";
      case (modeSel)
        3'd1, 3'd3: nOut = 1'b1;
        3'd5, 3'd7: nOut = 1'b0;
        default:    nOut = !mOut;
      endcase
    end else outTag = dual ? "R6" : "R5";
    @(posedge clk);
    mOut = nOut; mFlag = nFlag; mCmp = nCmp; mPrevEq = eq;
    @(negedge clk);
    compareAll();
  endtask

  task automatic writeCmp(int v);
    cmpWrEn = 1'b1; cmpWrData = 16'(v);
    step();
    cmpWrEn = 1'b0;
  endtask

  // wrapping counter from 0 to top; periodEnd on top
  task automatic runCount(int cycles, int top);
    for (int i = 0; i < cycles; i++) begin
      periodEnd = (int'(timerCount) == top);
      flagClrWr = rnd(6);
      step();
      timerCount = (int'(timerCount) >= top) ? 16'd0 : timerCount + 16'd1;
    end
    periodEnd = 1'b0;
    flagClrWr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; timerCount = 16'd3; periodEnd = 1'b0; cmpWrEn = 1'b0;
    cmpWrData = 16'd0; modeSel = 3'd1; captureSel = 1'b0; swOut = 1'b1;
    flagClrWr = 1'b0; intEnable = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "outPin", 16'(outPin), 16'd0);
    chk("R10", "matchFlag", 16'(matchFlag), 16'd0);
    chk("R10", "cmpValue", cmpValue, 16'd0);
    mOut = 0; mFlag = 0; mCmp = 0; mPrevEq = 0; outTag = "R10";
    rstN = 1'b1;
    timerCount = 16'd0;

    // R4 software mode
    modeSel = 3'd0;
    for (int i = 0; i < 8; i++) begin
      swOut = rnd(2);
      step();
    end
    writeCmp(5);

    // R5 R6 every compare mode, with period 12
    for (int m = 1; m < 8; m++) begin
      modeSel = 3'(m);
      intEnable = (m % 2 == 1);
      timerCount = 16'd0;
      runCount(40, 12);
    end

    // R7 match on threshold cycle in dual modes
    writeCmp(12);
    for (int m = 2; m < 8; m++) begin
      if (m == 4 || m == 5) continue;
      modeSel = 3'(m);
      timerCount = 16'd0;
      runCount(30, 12);
    end

    // R2 held count: single event, toggles once
    writeCmp(7);
    modeSel = 3'd4;
    timerCount = 16'd7;
    repeat (5) step();
    timerCount = 16'd8;
    step();

    // R3 clear together with an event: set wins
    flagClrWr = 1'b1; timerCount = 16'd9; step();
    timerCount = 16'd7; step();
    flagClrWr = 1'b0; step();

    // R8 capture parks the channel, including software mode
    captureSel = 1'b1;
    flagClrWr = 1'b1; step(); flagClrWr = 1'b0;
    timerCount = 16'd0;
    runCount(25, 12);
    modeSel = 3'd0;
    swOut = !outPin;
    repeat (3) step();
    captureSel = 1'b0;
    step();

    // R1 readback across a sweep of values
    for (int v = 0; v < 16; v++) writeCmp(v * 4099);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule